// File: doc/BRIEF.md
# Sprite List Double-Delay Buffer and Cell Expander

This block sits between the CPU-visible sprite table and the sprite drawing engine of a tile-and-sprite video pipeline. The CPU writes sprite descriptors into a live table of 1024 16-bit words. Each rising edge of the vertical-blank input starts a copy through two chained buffer stages. The oldest stage takes the contents of the newer stage, and the newer stage takes the live table. The list the expander walks therefore trails CPU writes by two frames.

The renderer requests a priority pass (0 to 3) after it has drawn the tile layers for that priority. The expander then scans the oldest buffer one four-word descriptor at a time and skips descriptors of any other priority. For each descriptor that matches, it offers one draw command per 8x8 cell on a valid/ready handshake. A command carries the tile code, the colour, both mirror flags and a wrapped 9-bit screen position. A one-cycle done pulse ends the pass. A buffer copy always wins over expansion.

Top module: `spr_pipe`

## Requirements
- R1: After reset, the outputs `cmd_valid_o`, `pass_done_o` and `copy_busy_o` are low, and all three sprite tables read as zero. A pass of priority 0 over the cleared table therefore yields 256 single-cell commands with code 0, colour 0, X = 44 and Y = 503.
- R2: Each vertical-blank rising edge copies the newer buffer into the oldest buffer and the live table into the newer buffer, word by word. A pass walks the oldest buffer, so it reflects the live table as it stood two copies earlier.
- R3: A copy starts on the cycle after a low-to-high transition of `vblank_i`. `copy_busy_o` stays high for exactly 1024 cycles. Holding `vblank_i` high starts no further copy.
- R4: Descriptors are scanned from word address 0 upward, four words per descriptor. Word 0 of each descriptor sits at an address that is a multiple of 4, and commands come out in descriptor order.
- R5: A descriptor is expanded only when its priority field (word 0 bits 10:9) equals the requested pass value. All other descriptors produce no command.
- R6: The command colour is word 0 bits 8:2. The base tile code is {word 0 bits 1:0, word 1}. The horizontal mirror flag is word 0 bit 12 XOR the screen flip input. The vertical mirror flag equals the screen flip input.
- R7: The width in cells is word 2 bits 3:0 plus 1, and the height in cells is word 3 bits 3:0 plus 1. Cells are emitted row by row, left column first. The cell at column x and row y has code (base + x + width*y) mod 2^18.
- R8: The origin X is word 2 bits 15:7 and the origin Y is word 3 bits 15:7. Cell X is origin X + 8x − scroll X + 44. Cell Y is origin Y + 8y − scroll Y − 9. Both are taken modulo 512.
- R9: With the screen flip input high at the pass request, the origin becomes (246 − X, 16 − Y). A mirrored axis uses −8(i+1)+1 in place of 8i for its cell offset.
- R10: A command that is offered and not accepted stays offered, with unchanged fields, until `cmd_ready_i` is high.
- R11: After the last descriptor of a pass has been handled, `pass_done_o` is high for exactly one cycle, with no command offered in that cycle. The pass parameters are sampled when the request is taken.
- R12: While a copy runs, no command is offered and no done pulse is given. A pass requested during a copy is held and runs once the copy has finished, over the freshly copied buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vblank_i | input | 1 | Vertical-blank level; its rising edge starts a copy |
| cpu_we_i | input | 1 | Live-table write strobe |
| cpu_addr_i | input | 10 | Live-table word address |
| cpu_wdata_i | input | 16 | Live-table write data |
| pass_req_i | input | 1 | Request a priority pass (taken while idle) |
| pass_sel_i | input | 2 | Priority of the requested pass |
| flip_i | input | 1 | Screen flip for the requested pass |
| scroll_x_i | input | 16 | Horizontal scroll register value |
| scroll_y_i | input | 16 | Vertical scroll register value |
| cmd_valid_o | output | 1 | Draw command offered |
| cmd_ready_i | input | 1 | Draw command accepted |
| cmd_code_o | output | 18 | Cell tile code |
| cmd_color_o | output | 7 | Cell colour |
| cmd_flipx_o | output | 1 | Horizontal mirror |
| cmd_flipy_o | output | 1 | Vertical mirror |
| cmd_x_o | output | 9 | Wrapped screen X |
| cmd_y_o | output | 9 | Wrapped screen Y |
| pass_done_o | output | 1 | One-cycle end-of-pass pulse |
| copy_busy_o | output | 1 | Buffer copy in progress |

## Verification
The bench targets the two-frame lag. A design that copied the live table straight into the walked buffer would show the current frame one frame early. A level-held vertical blank is also tested: a design that detected the level instead of the edge would re-copy continuously. Cell arithmetic is probed at the extremes: a 16x16 sprite, a base code at the top of the 18-bit range that must wrap, origins near 0 and 511 under flip, and mirrored offsets. An error there moves cells by 8 pixels or fails to wrap. A pass requested in the middle of a copy must stay silent until the copy ends and must then read the new buffer. A design that let expansion race the copy would emit cells drawn from a half-copied list.

// File: rtl/spr_pipe_pkg.sv
package spr_pipe_pkg;

    localparam int WORD_W  = 16;
    localparam int CODE_W  = 18;
    localparam int COLOR_W = 7;
    localparam int POS_W   = 9;
    localparam int DIM_W   = 4;
    localparam int PRI_W   = 2;

    // screen placement constants (modulo 2^POS_W)
    localparam logic [POS_W-1:0] X_BIAS      = 9'd44;
    localparam logic [POS_W-1:0] Y_BIAS      = 9'd503;   // -9
    localparam logic [POS_W-1:0] X_FLIP_ANCH = 9'd246;
    localparam logic [POS_W-1:0] Y_FLIP_ANCH = 9'd16;

    typedef logic [3:0][WORD_W-1:0] spr_desc_t;

    typedef struct packed {
        logic [CODE_W-1:0]  code;
        logic [COLOR_W-1:0] color;
        logic               flipx;
        logic               flipy;
        logic [POS_W-1:0]   x;
        logic [POS_W-1:0]   y;
    } cell_cmd_t;

    typedef enum logic [2:0] {
        EX_IDLE,
        EX_FETCH,
        EX_CHECK,
        EX_EMIT,
        EX_DONE
    } ex_state_t;

    function automatic logic [PRI_W-1:0] desc_prio(input spr_desc_t d);
        return d[0][10:9];
    endfunction

    function automatic logic [DIM_W-1:0] desc_wm1(input spr_desc_t d);
        return d[2][DIM_W-1:0];
    endfunction

    function automatic logic [DIM_W-1:0] desc_hm1(input spr_desc_t d);
        return d[3][DIM_W-1:0];
    endfunction

    // origin after optional screen flip
    function automatic logic [POS_W-1:0] flip_origin(
        input logic [POS_W-1:0] raw,
        input logic             flip,
        input logic [POS_W-1:0] anchor
    );
        return flip ? (anchor - raw) : raw;
    endfunction

    // one axis of the cell position, wrapped to POS_W bits
    function automatic logic [POS_W-1:0] cell_pos(
        input logic [POS_W-1:0]  origin,
        input logic [DIM_W-1:0]  idx,
        input logic              mirror,
        input logic [WORD_W-1:0] scroll,
        input logic [POS_W-1:0]  bias
    );
        logic [DIM_W:0]   nxt;
        logic [POS_W-1:0] step;
        nxt  = {1'b0, idx} + 1'b1;
        step = mirror ? (POS_W'(1) - POS_W'({nxt, 3'b000}))
                      : POS_W'({idx, 3'b000});
        return origin + step - scroll[POS_W-1:0] + bias;
    endfunction

endpackage

// File: rtl/spr_list_bufs.sv
module spr_list_bufs
    import spr_pipe_pkg::*;
#(
    parameter int NUM_WORDS = 1024
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         vblank_i,
    input  logic                         cpu_we_i,
    input  logic [$clog2(NUM_WORDS)-1:0] cpu_addr_i,
    input  logic [WORD_W-1:0]            cpu_wdata_i,
    input  logic [$clog2(NUM_WORDS)-1:0] rd_addr_i,
    output logic [WORD_W-1:0]            rd_data_o,
    output logic                         copy_busy_o
);
    localparam int AW = $clog2(NUM_WORDS);
    localparam logic [AW-1:0] LAST_ADDR = AW'(NUM_WORDS - 1);

    logic [WORD_W-1:0] live_mem  [NUM_WORDS];
    logic [WORD_W-1:0] newer_mem [NUM_WORDS];
    logic [WORD_W-1:0] older_mem [NUM_WORDS];

    logic          vb_q;
    logic          busy_q;
    logic [AW-1:0] cp_addr_q;
    logic          vb_rise;

    assign vb_rise = vblank_i & ~vb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vb_q      <= 1'b0;
            busy_q    <= 1'b0;
            cp_addr_q <= '0;
        end else begin
            vb_q <= vblank_i;
            if (busy_q) begin
                cp_addr_q <= cp_addr_q + 1'b1;
                if (cp_addr_q == LAST_ADDR) busy_q <= 1'b0;
            end else if (vb_rise) begin
                busy_q    <= 1'b1;
                cp_addr_q <= '0;
            end
        end
    end

    // tables: both stages move one word per cycle so the oldest stage
    // always receives the newer stage's previous value
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                live_mem[i]  <= '0;
                newer_mem[i] <= '0;
                older_mem[i] <= '0;
            end
        end else begin
            if (cpu_we_i) live_mem[cpu_addr_i] <= cpu_wdata_i;
            if (busy_q) begin
                older_mem[cp_addr_q] <= newer_mem[cp_addr_q];
                newer_mem[cp_addr_q] <= live_mem[cp_addr_q];
            end
        end
    end

    assign rd_data_o   = older_mem[rd_addr_i];
    assign copy_busy_o = busy_q;

endmodule

// File: rtl/spr_cell_calc.sv
module spr_cell_calc
    import spr_pipe_pkg::*;
(
    input  spr_desc_t         desc_i,
    input  logic [DIM_W-1:0]  cx_i,
    input  logic [DIM_W-1:0]  cy_i,
    input  logic              flip_i,
    input  logic [WORD_W-1:0] scroll_x_i,
    input  logic [WORD_W-1:0] scroll_y_i,
    output cell_cmd_t         cmd_o
);
    logic [CODE_W-1:0] base_code;
    logic [DIM_W:0]    width;
    logic              mir [2];
    logic [POS_W-1:0]  pos [2];

    assign base_code = {desc_i[0][1:0], desc_i[1]};
    assign width     = {1'b0, desc_wm1(desc_i)} + 1'b1;
    assign mir[0]    = desc_i[0][12] ^ flip_i;
    assign mir[1]    = flip_i;

    // one position unit per screen axis
    for (genvar a = 0; a < 2; a++) begin : g_axis
        localparam logic [POS_W-1:0] ANCH = (a == 0) ? X_FLIP_ANCH : Y_FLIP_ANCH;
        localparam logic [POS_W-1:0] BIAS = (a == 0) ? X_BIAS : Y_BIAS;
        logic [POS_W-1:0] raw;
        logic [POS_W-1:0] org;
        assign raw    = desc_i[2 + a][WORD_W-1:WORD_W-POS_W];
        assign org    = flip_origin(raw, flip_i, ANCH);
        assign pos[a] = cell_pos(org, (a == 0) ? cx_i : cy_i, mir[a],
                                 (a == 0) ? scroll_x_i : scroll_y_i, BIAS);
    end

    always_comb begin
        cmd_o.code  = base_code + CODE_W'(cx_i) + (CODE_W'(width) * CODE_W'(cy_i));
        cmd_o.color = desc_i[0][8:2];
        cmd_o.flipx = mir[0];
        cmd_o.flipy = mir[1];
        cmd_o.x     = pos[0];
        cmd_o.y     = pos[1];
    end

endmodule

// File: rtl/spr_cell_expander.sv
module spr_cell_expander
    import spr_pipe_pkg::*;
#(
    parameter int NUM_WORDS = 1024
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         copy_busy_i,
    input  logic                         pass_req_i,
    input  logic [PRI_W-1:0]             pass_sel_i,
    input  logic                         flip_i,
    input  logic [WORD_W-1:0]            scroll_x_i,
    input  logic [WORD_W-1:0]            scroll_y_i,
    output logic [$clog2(NUM_WORDS)-1:0] rd_addr_o,
    input  logic [WORD_W-1:0]            rd_data_i,
    output logic                         cmd_valid_o,
    input  logic                         cmd_ready_i,
    output cell_cmd_t                    cmd_o,
    output logic                         pass_done_o
);
    localparam int NUM_DESC = NUM_WORDS / 4;
    localparam int EW       = $clog2(NUM_DESC);
    localparam logic [EW-1:0] LAST_DESC = EW'(NUM_DESC - 1);

    ex_state_t         state_q;
    logic              pend_q;
    logic [PRI_W-1:0]  pass_q;
    logic              flip_q;
    logic [WORD_W-1:0] scx_q, scy_q;
    logic [EW-1:0]     ent_q;
    logic [1:0]        widx_q;
    spr_desc_t         desc_q;
    logic [DIM_W-1:0]  cx_q, cy_q;

    assign rd_addr_o = {ent_q, widx_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= EX_IDLE;
            pend_q  <= 1'b0;
            pass_q  <= '0;
            flip_q  <= 1'b0;
            scx_q   <= '0;
            scy_q   <= '0;
            ent_q   <= '0;
            widx_q  <= '0;
            desc_q  <= '0;
            cx_q    <= '0;
            cy_q    <= '0;
        end else begin
            // take a request while idle; it waits out any copy
            if (pass_req_i && state_q == EX_IDLE && !pend_q) begin
                pend_q <= 1'b1;
                pass_q <= pass_sel_i;
                flip_q <= flip_i;
                scx_q  <= scroll_x_i;
                scy_q  <= scroll_y_i;
            end
            if (!copy_busy_i) begin
                unique case (state_q)
                    EX_IDLE: begin
                        if (pend_q) begin
                            pend_q  <= 1'b0;
                            ent_q   <= '0;
                            widx_q  <= '0;
                            state_q <= EX_FETCH;
                        end
                    end
                    EX_FETCH: begin
                        desc_q[widx_q] <= rd_data_i;
                        widx_q         <= widx_q + 1'b1;
                        if (widx_q == 2'd3) state_q <= EX_CHECK;
                    end
                    EX_CHECK: begin
                        if (desc_prio(desc_q) == pass_q) begin
                            cx_q    <= '0;
                            cy_q    <= '0;
                            state_q <= EX_EMIT;
                        end else if (ent_q == LAST_DESC) begin
                            state_q <= EX_DONE;
                        end else begin
                            ent_q   <= ent_q + 1'b1;
                            state_q <= EX_FETCH;
                        end
                    end
                    EX_EMIT: begin
                        if (cmd_ready_i) begin
                            if (cx_q != desc_wm1(desc_q)) begin
                                cx_q <= cx_q + 1'b1;
                            end else begin
                                cx_q <= '0;
                                if (cy_q != desc_hm1(desc_q)) begin
                                    cy_q <= cy_q + 1'b1;
                                end else if (ent_q == LAST_DESC) begin
                                    state_q <= EX_DONE;
                                end else begin
                                    ent_q   <= ent_q + 1'b1;
                                    state_q <= EX_FETCH;
                                end
                            end
                        end
                    end
                    EX_DONE: state_q <= EX_IDLE;
                    default: state_q <= EX_IDLE;
                endcase
            end
        end
    end

    spr_cell_calc u_calc (
        .desc_i     (desc_q),
        .cx_i       (cx_q),
        .cy_i       (cy_q),
        .flip_i     (flip_q),
        .scroll_x_i (scx_q),
        .scroll_y_i (scy_q),
        .cmd_o      (cmd_o)
    );

    assign cmd_valid_o = (state_q == EX_EMIT) && !copy_busy_i;
    assign pass_done_o = (state_q == EX_DONE) && !copy_busy_i;

endmodule

// File: rtl/spr_pipe.sv
module spr_pipe
    import spr_pipe_pkg::*;
#(
    parameter int NUM_WORDS = 1024,
    localparam int AW = $clog2(NUM_WORDS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               vblank_i,
    input  logic               cpu_we_i,
    input  logic [AW-1:0]      cpu_addr_i,
    input  logic [WORD_W-1:0]  cpu_wdata_i,
    input  logic               pass_req_i,
    input  logic [PRI_W-1:0]   pass_sel_i,
    input  logic               flip_i,
    input  logic [WORD_W-1:0]  scroll_x_i,
    input  logic [WORD_W-1:0]  scroll_y_i,
    output logic               cmd_valid_o,
    input  logic               cmd_ready_i,
    output logic [CODE_W-1:0]  cmd_code_o,
    output logic [COLOR_W-1:0] cmd_color_o,
    output logic               cmd_flipx_o,
    output logic               cmd_flipy_o,
    output logic [POS_W-1:0]   cmd_x_o,
    output logic [POS_W-1:0]   cmd_y_o,
    output logic               pass_done_o,
    output logic               copy_busy_o
);
    logic [AW-1:0]     rd_addr;
    logic [WORD_W-1:0] rd_data;
    logic              busy;
    cell_cmd_t         cmd;

    spr_list_bufs #(.NUM_WORDS(NUM_WORDS)) u_bufs (
        .clk         (clk),
        .rst         (rst),
        .vblank_i    (vblank_i),
        .cpu_we_i    (cpu_we_i),
        .cpu_addr_i  (cpu_addr_i),
        .cpu_wdata_i (cpu_wdata_i),
        .rd_addr_i   (rd_addr),
        .rd_data_o   (rd_data),
        .copy_busy_o (busy)
    );

    spr_cell_expander #(.NUM_WORDS(NUM_WORDS)) u_exp (
        .clk         (clk),
        .rst         (rst),
        .copy_busy_i (busy),
        .pass_req_i  (pass_req_i),
        .pass_sel_i  (pass_sel_i),
        .flip_i      (flip_i),
        .scroll_x_i  (scroll_x_i),
        .scroll_y_i  (scroll_y_i),
        .rd_addr_o   (rd_addr),
        .rd_data_i   (rd_data),
        .cmd_valid_o (cmd_valid_o),
        .cmd_ready_i (cmd_ready_i),
        .cmd_o       (cmd),
        .pass_done_o (pass_done_o)
    );

    assign cmd_code_o  = cmd.code;
    assign cmd_color_o = cmd.color;
    assign cmd_flipx_o = cmd.flipx;
    assign cmd_flipy_o = cmd.flipy;
    assign cmd_x_o     = cmd.x;
    assign cmd_y_o     = cmd.y;
    assign copy_busy_o = busy;

endmodule

// File: rtl/spr_pipe_chk.sv
module spr_pipe_chk
    import spr_pipe_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               vblank_i,
    input logic               copy_busy_o,
    input logic               cmd_valid_o,
    input logic               cmd_ready_i,
    input logic [CODE_W-1:0]  cmd_code_o,
    input logic [COLOR_W-1:0] cmd_color_o,
    input logic [POS_W-1:0]   cmd_x_o,
    input logic [POS_W-1:0]   cmd_y_o,
    input logic               pass_done_o
);
    AST_NO_CMD_IN_COPY: assert property (@(posedge clk) disable iff (rst)
        copy_busy_o |-> !cmd_valid_o);                                       // R12

    AST_NO_DONE_IN_COPY: assert property (@(posedge clk) disable iff (rst)
        copy_busy_o |-> !pass_done_o);                                       // R12

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_o && !cmd_ready_i) |=> (copy_busy_o ||
            (cmd_valid_o && $stable(cmd_code_o) && $stable(cmd_color_o) &&
             $stable(cmd_x_o) && $stable(cmd_y_o))));                        // R10

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        pass_done_o |=> !pass_done_o);                                       // R11

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        pass_done_o |-> !cmd_valid_o);                                       // R11

    AST_COPY_STARTS: assert property (@(posedge clk) disable iff (rst)
        ($rose(vblank_i) && !copy_busy_o) |=> copy_busy_o);                 // R3
endmodule

bind spr_pipe spr_pipe_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .vblank_i    (vblank_i),
    .copy_busy_o (copy_busy_o),
    .cmd_valid_o (cmd_valid_o),
    .cmd_ready_i (cmd_ready_i),
    .cmd_code_o  (cmd_code_o),
    .cmd_color_o (cmd_color_o),
    .cmd_x_o     (cmd_x_o),
    .cmd_y_o     (cmd_y_o),
    .pass_done_o (pass_done_o)
);

// File: tb/spr_pipe_tb.sv
`timescale 1ns/1ps
module spr_pipe_tb;
    localparam int NW = 1024;
    localparam int ND = NW / 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vblank = 1'b0;
    logic        we = 1'b0;
    logic [9:0]  waddr = '0;
    logic [15:0] wdata = '0;
    logic        req = 1'b0;
    logic [1:0]  psel = '0;
    logic        flip = 1'b0;
    logic [15:0] scx = '0, scy = '0;
    logic        valid, ready = 1'b0;
    logic [17:0] code;
    logic [6:0]  color;
    logic        fx, fy;
    logic [8:0]  px, py;
    logic        done, busy;

    always #2.5 clk = ~clk;

    spr_pipe u_dut (
        .clk(clk), .rst(rst), .vblank_i(vblank), .cpu_we_i(we),
        .cpu_addr_i(waddr), .cpu_wdata_i(wdata), .pass_req_i(req),
        .pass_sel_i(psel), .flip_i(flip), .scroll_x_i(scx), .scroll_y_i(scy),
        .cmd_valid_o(valid), .cmd_ready_i(ready), .cmd_code_o(code),
        .cmd_color_o(color), .cmd_flipx_o(fx), .cmd_flipy_o(fy),
        .cmd_x_o(px), .cmd_y_o(py), .pass_done_o(done), .copy_busy_o(busy)
    );

    int n_tests = 0;
    int n_fail  = 0;

    logic [15:0] m_live [NW];
    logic [15:0] m_new  [NW];
    logic [15:0] m_old  [NW];
    logic [44:0] exp_q [$];

    task automatic check(input bit ok, input string req_tag,
                         input logic [63:0] act, input logic [63:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req_tag, act, expv);
        end
    endtask

    // expected command list for one pass, computed from the requirements
    task automatic build_expected(input int pass, input bit fl, input int sx_reg, input int sy_reg);
        exp_q.delete();
        for (int e = 0; e < ND; e++) begin
            logic [15:0] w0, w1, w2, w3;
            int wd, ht, base, ox, oy;
            w0 = m_old[4*e]; w1 = m_old[4*e+1]; w2 = m_old[4*e+2]; w3 = m_old[4*e+3];
            if (int'(w0[10:9]) != pass) continue;
            wd = int'(w2[3:0]) + 1;
            ht = int'(w3[3:0]) + 1;
            base = int'({w0[1:0], w1});
            ox = int'(w2[15:7]);
            oy = int'(w3[15:7]);
            if (fl) begin ox = 246 - ox; oy = 16 - oy; end
            for (int y = 0; y < ht; y++) begin
                for (int x = 0; x < wd; x++) begin
                    int c, xo, yo, X, Y;
                    bit mx, my;
                    mx = w0[12] ^ fl;
                    my = fl;
                    c  = (base + x + wd*y) & 32'h3FFFF;
                    xo = mx ? (-8*(x+1) + 1) : 8*x;
                    yo = my ? (-8*(y+1) + 1) : 8*y;
                    X  = (ox + xo - sx_reg + 44) & 511;
                    Y  = (oy + yo - sy_reg - 9) & 511;
                    exp_q.push_back({18'(c), w0[8:2], mx, my, 9'(X), 9'(Y)});
                end
            end
        end
    endtask

    task automatic run_pass(input int pass, input bit fl, input logic [15:0] sxr,
                            input logic [15:0] syr, input string tag);
        int cyc;
        bit seen_done;
        build_expected(pass, fl, int'(sxr), int'(syr));
        @(negedge clk);
        req = 1'b1; psel = 2'(pass); flip = fl; scx = sxr; scy = syr;
        @(negedge clk);
        req = 1'b0; flip = 1'b0; scx = 16'hFFFF; scy = 16'h1234; // changes after request must not matter (R11)
        seen_done = 1'b0;
        cyc = 0;
        while (!seen_done && cyc < 150000) begin
            @(negedge clk);
            cyc++;
            ready = ($urandom % 4) != 0;
            #0.5;
            if (busy && valid) check(1'b0, "R12 command during copy", 64'(valid), 64'd0);
            if (valid && ready) begin
                logic [44:0] act;
                act = {code, color, fx, fy, px, py};
                if (exp_q.size() == 0) begin
                    check(1'b0, {tag, " extra command"}, 64'(act), 64'd0);
                end else begin
                    logic [44:0] ex;
                    ex = exp_q.pop_front();
                    check(act == ex, tag, 64'(act), 64'(ex));
                end
            end
            if (done) begin
                seen_done = 1'b1;
                check(!valid, "R11 done with command", 64'(valid), 64'd0);
            end
        end
        check(seen_done && exp_q.size() == 0, {tag, " R11 pass end / leftover cells"},
              64'(exp_q.size()), 64'd0);
        @(negedge clk);
        check(!done, "R11 done longer than one cycle", 64'(done), 64'd0);
        ready = 1'b0;
    endtask

    task automatic write_live(input int a, input logic [15:0] d);
        @(negedge clk);
        we = 1'b1; waddr = 10'(a); wdata = d;
        m_live[a] = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic fill_frame(input bit corners);
        for (int e = 0; e < ND; e++) begin
            logic [15:0] w0, w1, w2, w3;
            w0 = 16'($urandom);
            w1 = 16'($urandom);
            w2 = {9'($urandom), 3'($urandom), 4'($urandom % 3)};
            w3 = {9'($urandom), 3'($urandom), 4'($urandom % 3)};
            if (corners && e == 5) begin   // largest sprite, code wraps at 2^18
                w0[1:0] = 2'b11; w1 = 16'hFFF0; w2[3:0] = 4'hF; w3[3:0] = 4'hF;
                w2[15:7] = 9'd0; w3[15:7] = 9'd511;
            end
            if (corners && e == 200) begin w2[15:7] = 9'd511; w3[15:7] = 9'd0; end
            for (int k = 0; k < 4; k++) begin
                logic [15:0] wv;
                wv = (k == 0) ? w0 : (k == 1) ? w1 : (k == 2) ? w2 : w3;
                @(negedge clk);
                we = 1'b1; waddr = 10'(4*e + k); wdata = wv;
                m_live[4*e + k] = wv;
            end
        end
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic vblank_rise();
        @(negedge clk);
        vblank = 1'b1;
        for (int i = 0; i < NW; i++) begin
            m_old[i] = m_new[i];
            m_new[i] = m_live[i];
        end
    endtask

    task automatic wait_copy(input bit check_len);
        int cnt;
        cnt = 0;
        @(negedge clk);
        while (busy) begin cnt++; @(negedge clk); end
        if (check_len) check(cnt == NW, "R3 copy length", 64'(cnt), 64'(NW));
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < NW; i++) begin m_live[i] = '0; m_new[i] = '0; m_old[i] = '0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!valid && !done && !busy, "R1 reset outputs",
              64'({valid, done, busy}), 64'd0);

        // cleared tables: 256 single cells of code 0 at (44, 503)
        run_pass(0, 1'b0, 16'd0, 16'd0, "R1 R4 R8 cleared table");

        // frame A written; first copy still leaves the oldest stage cleared
        fill_frame(1'b0);
        vblank_rise();
        wait_copy(1'b1);
        @(negedge clk); vblank = 1'b0;
        run_pass(0, 1'b0, 16'd3, 16'd7, "R2 two-frame lag");

        // frame B; second copy brings frame A into view
        fill_frame(1'b1);
        vblank_rise();
        wait_copy(1'b1);
        @(negedge clk); vblank = 1'b0;
        for (int p = 0; p < 4; p++)
            run_pass(p, 1'b0, 16'($urandom), 16'($urandom), "R4 R5 R6 R7 R8 R10 frame A");

        // frame B (corner sprites) into view
        vblank_rise();
        wait_copy(1'b1);
        run_pass(int'(m_old[20][10:9]), 1'b0, 16'h0102, 16'h01F0, "R6 R7 R8 R10 large/wrapping");
        run_pass(int'(m_old[20][10:9]), 1'b1, 16'h0033, 16'h0100, "R9 flipped large");
        run_pass(int'(m_old[800][10:9]), 1'b1, 16'($urandom), 16'($urandom), "R9 flipped near-edge");

        // vblank still high: new live data must not be copied
        for (int i = 0; i < 16; i++) write_live(i, 16'h0600 | 16'(i));
        repeat (50) begin
            @(negedge clk);
            if (busy) check(1'b0, "R3 copy on level", 64'(busy), 64'd0);
        end
        check(!busy, "R3 no copy while level high", 64'(busy), 64'd0);
        run_pass(3, 1'b0, 16'd0, 16'd0, "R3 R5 unchanged after held level");
        @(negedge clk); vblank = 1'b0;

        // request during copy is held and reads the fresh buffer
        repeat (3) @(negedge clk);
        vblank_rise();
        run_pass(3, 1'b1, 16'h0040, 16'h0008, "R12 R2 pass held through copy");
        @(negedge clk); vblank = 1'b0;
        run_pass(1, 1'b0, 16'h0001, 16'h0002, "R5 R12 after copy");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule